// File: doc/BRIEF.md
# Serial LED Status Shifter

This block gathers the status of an eight-port repeater and sends it to a chain of external LED shift registers. The status is the partition state and receive activity of every port, a collision flag for each speed domain, and a memory self-test failure flag. The block drives a gated serial clock and a data line. Each burst carries one fixed 24-bit frame, and bursts repeat at a long, fixed interval. The block also drives one active-low LED line per port for partition and one for receive activity, straight from the status inputs.

A controller with three states runs the serial side.

- IDLE waits out the gap between bursts. The IDLE to LOAD transition fires when the gap timer expires.
- LOAD takes a snapshot of the status word in one cycle. The LOAD to SHIFT transition is unconditional.
- SHIFT runs one serial bit per `CLK_DIV` system cycles, with the clock low for the first half of the bit and high for the second half. The SHIFT to SHIFT transition advances to the next bit at the end of each bit. The SHIFT to IDLE transition fires at the end of the last bit.

With a 50 MHz system clock and `CLK_DIV` = 8, the serial clock period is 160 ns. The default gap gives one burst every 2,100,000 cycles, which is 42 ms.

Top module: `led_status_serializer`

## Requirements
- R1: Every burst has exactly 3*NUM_PORTS (24) rising edges on `led_sclk_o`, and there are none between bursts.
- R2: Frame bit 0 is sent first, at the first rising edge. Frame bits 0..7 carry `part_i[0]`..`part_i[7]`.
- R3: Frame bit 8 carries `col10_i`, bit 9 carries `col100_i` and bit 10 carries `memfail_i`.
- R4: Frame bits 11..15 repeat `part_i[3]`..`part_i[7]`.
- R5: Frame bits 16..23 carry `act_i[0]`..`act_i[7]`.
- R6: Within a burst, `led_sclk_o` stays high for CLK_DIV/2 cycles and low for CLK_DIV/2 cycles between pulses. It stays low in IDLE.
- R7: `led_sdat_o` is active high. It changes only while the clock is low, so it is stable through each high phase. It is low in IDLE.
- R8: The first rising edges of consecutive bursts are GAP_CYCLES + 1 + 3*NUM_PORTS*CLK_DIV system cycles apart, which is 233 cycles with GAP_CYCLES = 40.
- R9: The frame is sampled once, in LOAD. Status changes during SHIFT do not alter the frame being sent.
- R10: `part_led_n_o` equals the bitwise inverse of `part_i`, and `act_led_n_o` equals the bitwise inverse of `act_i`.
- R11: While `rst_n` is low, `led_sclk_o` and `led_sdat_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| part_i | input | NUM_PORTS | Per-port partition status, 1 = partitioned |
| act_i | input | NUM_PORTS | Per-port receive activity, 1 = active |
| col10_i | input | 1 | Collision in the 10 Mb/s domain |
| col100_i | input | 1 | Collision in the 100 Mb/s domain |
| memfail_i | input | 1 | Memory self-test failed |
| led_sclk_o | output | 1 | Gated serial clock to the LED shift chain |
| led_sdat_o | output | 1 | Serial data, active high |
| part_led_n_o | output | NUM_PORTS | Direct partition LEDs, active low |
| act_led_n_o | output | NUM_PORTS | Direct activity LEDs, active low |

## Verification
The hardest case to reach from the ports is proving that the frame is a snapshot taken in LOAD. To do so, the inputs must change after the burst has started but before it ends.

The bench first holds one status pattern for two whole bursts. It then waits for the first rising serial edge of the next burst and switches to a very different pattern at once. It checks that the captured frame is still the first pattern. A passive receiver also runs through every burst and measures pulse widths, data stability and the spacing between bursts.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } led_state_e;

endpackage

// File: rtl/led_frame_map.sv
module led_frame_map #(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0]   part_i,
    input  logic [NUM_PORTS-1:0]   act_i,
    input  logic                   col10_i,
    input  logic                   col100_i,
    input  logic                   memfail_i,
    output logic [3*NUM_PORTS-1:0] frame_o
);
    localparam int FLAG_BASE = NUM_PORTS;
    localparam int REP_BASE  = NUM_PORTS + 3;
    localparam int REP_FIRST = 3;
    localparam int ACT_BASE  = 2*NUM_PORTS;

    // partition field, then the three flags
    assign frame_o[NUM_PORTS-1:0]  = part_i;
    assign frame_o[FLAG_BASE]      = col10_i;
    assign frame_o[FLAG_BASE + 1]  = col100_i;
    assign frame_o[FLAG_BASE + 2]  = memfail_i;

    // upper partition ports repeated
    for (genvar g = REP_FIRST; g < NUM_PORTS; g++) begin : g_rep
        assign frame_o[REP_BASE + g - REP_FIRST] = part_i[g];
    end

    // receive activity field
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_act
        assign frame_o[ACT_BASE + g] = act_i[g];
    end
endmodule

// File: rtl/led_gap_timer.sv
module led_gap_timer #(
    parameter int GAP_CYCLES = 2_099_807
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run_i)   cnt_q <= '0;
        else if (!done_o)  cnt_q <= cnt_q + 1'b1;
        else               cnt_q <= '0;
    end

    assign done_o = run_i && (cnt_q == CNT_W'(GAP_CYCLES - 1));
endmodule

// File: rtl/led_bit_phase.sv
module led_bit_phase #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mid_o,
    output logic last_o
);
    localparam int PH_W = $clog2(CLK_DIV);
    localparam int HALF = CLK_DIV / 2;

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ph_q <= '0;
        else if (!run_i)  ph_q <= '0;
        else if (last_o)  ph_q <= '0;
        else              ph_q <= ph_q + 1'b1;
    end

    assign mid_o  = run_i && (ph_q == PH_W'(HALF - 1));
    assign last_o = run_i && (ph_q == PH_W'(CLK_DIV - 1));
endmodule

// File: rtl/led_status_serializer.sv
module led_status_serializer
    import led_ser_pkg::*;
#(
    parameter int NUM_PORTS  = 8,
    parameter int CLK_DIV    = 8,
    parameter int GAP_CYCLES = 2_099_807
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] part_i,
    input  logic [NUM_PORTS-1:0] act_i,
    input  logic                 col10_i,
    input  logic                 col100_i,
    input  logic                 memfail_i,
    output logic                 led_sclk_o,
    output logic                 led_sdat_o,
    output logic [NUM_PORTS-1:0] part_led_n_o,
    output logic [NUM_PORTS-1:0] act_led_n_o
);
    localparam int FRAME_BITS = 3 * NUM_PORTS;
    localparam int HALF       = CLK_DIV / 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    led_state_e state_q, state_d;

    logic [FRAME_BITS-1:0] frame_w;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BIT_W-1:0]      bitcnt_q;
    logic                  sclk_q;
    logic                  gap_done;
    logic                  ph_mid;
    logic                  ph_last;
    logic                  last_bit;
    logic                  shifting;

    led_frame_map #(.NUM_PORTS(NUM_PORTS)) u_map (
        .part_i    (part_i),
        .act_i     (act_i),
        .col10_i   (col10_i),
        .col100_i  (col100_i),
        .memfail_i (memfail_i),
        .frame_o   (frame_w)
    );

    led_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_IDLE),
        .done_o (gap_done)
    );

    led_bit_phase #(.CLK_DIV(CLK_DIV)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_SHIFT),
        .mid_o  (ph_mid),
        .last_o (ph_last)
    );

    assign last_bit = (bitcnt_q == BIT_W'(FRAME_BITS - 1));
    assign shifting = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (gap_done) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (ph_last && last_bit) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // frame snapshot and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    shreg_q  <= frame_w;
                    bitcnt_q <= '0;
                end
                ST_SHIFT: begin
                    if (ph_last) begin
                        shreg_q  <= shreg_q >> 1;
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // registered serial clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   sclk_q <= 1'b0;
        else if (state_q != ST_SHIFT) sclk_q <= 1'b0;
        else if (ph_mid)              sclk_q <= 1'b1;
        else if (ph_last)             sclk_q <= 1'b0;
    end

    assign led_sclk_o   = sclk_q;
    assign led_sdat_o   = shreg_q[0];
    assign part_led_n_o = ~part_i;
    assign act_led_n_o  = ~act_i;
endmodule

// File: rtl/led_ser_checker.sv
module led_ser_checker #(
    parameter int HALF       = 4,
    parameter int FRAME_BITS = 24
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdat,
    input logic busy
);
    localparam int RUN_W = $clog2(HALF + 1) + 1;
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic             sclk_d;
    logic [RUN_W-1:0] hi_run;
    logic [CNT_W-1:0] rise_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            hi_run   <= '0;
            rise_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            hi_run <= sclk ? hi_run + 1'b1 : '0;
            if (!busy)               rise_cnt <= '0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    AST_RISE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && !sclk_d) |-> (rise_cnt < CNT_W'(FRAME_BITS))); // R1
    AST_BURST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (rise_cnt == CNT_W'(FRAME_BITS))); // R1
    AST_HIGH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (hi_run < RUN_W'(HALF))); // R6
    AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run == RUN_W'(HALF))); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdat)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdat)); // R7
endmodule

bind led_status_serializer led_ser_checker #(
    .HALF       (HALF),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (led_sclk_o),
    .sdat  (led_sdat_o),
    .busy  (shifting)
);

// File: tb/sim_led_status_serializer.sv
module sim_led_status_serializer;
    localparam int NP     = 8;
    localparam int DIV    = 8;
    localparam int HALF   = DIV / 2;
    localparam int GAP    = 40;
    localparam int NBITS  = 3 * NP;
    localparam int PERIOD = GAP + 1 + NBITS * DIV;

    typedef struct packed {
        logic [7:0]  part;
        logic [7:0]  act;
        logic        c10;
        logic        c100;
        logic        mem;
        logic [23:0] exp;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 24'h000000},
        '{8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 24'h00F8FF},
        '{8'h00, 8'hA5, 1'b1, 1'b0, 1'b1, 24'hA50500},
        '{8'h81, 8'h3C, 1'b0, 1'b1, 1'b0, 24'h3C8281},
        '{8'h08, 8'hFF, 1'b1, 1'b1, 1'b1, 24'hFF0F08}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] part = '0;
    logic [NP-1:0] act = '0;
    logic          c10 = 1'b0;
    logic          c100 = 1'b0;
    logic          mem = 1'b0;
    logic          sclk, sdat;
    logic [NP-1:0] part_n, act_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    led_status_serializer #(
        .NUM_PORTS  (NP),
        .CLK_DIV    (DIV),
        .GAP_CYCLES (GAP)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .part_i       (part),
        .act_i        (act),
        .col10_i      (c10),
        .col100_i     (c100),
        .memfail_i    (mem),
        .led_sclk_o   (sclk),
        .led_sdat_o   (sdat),
        .part_led_n_o (part_n),
        .act_led_n_o  (act_n)
    );

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // passive receiver on the serial lines
    int          cyc = 0;
    bit          prev = 1'b0;
    bit          in_burst = 1'b0;
    bit          have_start = 1'b0;
    int          last_start = 0;
    int          pulses = 0;
    int          hi_run = 0;
    int          lo_run = 0;
    bit          cur_bit = 1'b0;
    logic [23:0] frame = '0;
    logic [23:0] last_frame = '0;
    int          burst_id = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sclk && !prev) begin
                if (!in_burst) begin
                    in_burst = 1'b1;
                    pulses = 0;
                    frame = '0;
                    if (have_start) chk(cyc - last_start == PERIOD, "R8", cyc - last_start, PERIOD);
                    last_start = cyc;
                    have_start = 1'b1;
                end else begin
                    chk(lo_run == HALF, "R6 low width", lo_run, HALF);
                end
                if (pulses < NBITS) frame[pulses] = sdat;
                cur_bit = sdat;
                pulses++;
                hi_run = 1;
                lo_run = 0;
            end else if (sclk) begin
                hi_run++;
                chk(sdat == cur_bit, "R7 data held", int'(sdat), int'(cur_bit));
            end else if (prev) begin
                chk(hi_run == HALF, "R6 high width", hi_run, HALF);
                lo_run = 1;
            end else begin
                lo_run++;
                if (in_burst && lo_run == 2 * DIV) begin
                    chk(pulses == NBITS, "R1 pulses", pulses, NBITS);
                    chk(sdat == 1'b0, "R7 idle data", int'(sdat), 0);
                    last_frame = frame;
                    in_burst = 1'b0;
                    burst_id++;
                end
            end
            prev = sclk;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_bursts(input int n);
        int target;
        target = burst_id + n;
        wait (burst_id >= target);
        @(negedge clk);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R11 sclk", int'(sclk), 0);
        chk(sdat == 1'b0, "R11 sdat", int'(sdat), 0);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            part = VECS[i].part;
            act  = VECS[i].act;
            c10  = VECS[i].c10;
            c100 = VECS[i].c100;
            mem  = VECS[i].mem;
            @(negedge clk);
            chk(part_n == ~VECS[i].part, "R10 partition LEDs", int'(part_n), int'(~VECS[i].part));
            chk(act_n == ~VECS[i].act, "R10 activity LEDs", int'(act_n), int'(~VECS[i].act));
            wait_bursts(2);
            chk(last_frame[7:0] == VECS[i].exp[7:0], "R2 partition bits",
                int'(last_frame[7:0]), int'(VECS[i].exp[7:0]));
            chk(last_frame[10:8] == VECS[i].exp[10:8], "R3 flag bits",
                int'(last_frame[10:8]), int'(VECS[i].exp[10:8]));
            chk(last_frame[15:11] == VECS[i].exp[15:11], "R4 repeated partition",
                int'(last_frame[15:11]), int'(VECS[i].exp[15:11]));
            chk(last_frame[23:16] == VECS[i].exp[23:16], "R5 activity bits",
                int'(last_frame[23:16]), int'(VECS[i].exp[23:16]));
        end

        // R9: change status right after a burst has started
        part = 8'h81; act = 8'h3C; c10 = 1'b0; c100 = 1'b1; mem = 1'b0;
        wait_bursts(2);
        @(posedge sclk);
        @(negedge clk);
        part = 8'h7E; act = 8'hC3; c10 = 1'b1; c100 = 1'b0; mem = 1'b1;
        wait_bursts(1);
        chk(last_frame == 24'h3C8281, "R9 snapshot", int'(last_frame), 24'h3C8281);
        wait_bursts(1);
        // new status: part 7E -> rep 0F<<11, act C3, flags 101
        chk(last_frame == 24'hC37D7E, "R9 next frame", int'(last_frame), 24'hC37D7E);

        // R11: reset mid-burst returns lines low
        @(posedge sclk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R11 sclk mid-burst", int'(sclk), 0);
        chk(sdat == 1'b0, "R11 sdat mid-burst", int'(sdat), 0);
        finish_run();
    end
endmodule